// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers interrupt request lines from peripherals and decides which one the processor should take next. Every request line sits at a fixed level from 1 to 7 and at a fixed slot within that level. The block picks the winning request and compares its level with the processor's current mask. It then presents a pending flag, a level and a vector number to the core. When the core acknowledges, the block returns the vector of the request that won.

Levels 1 to 6 are maskable and level-sensitive: a line counts only while it is held high and its level is above the mask. Level 7 is non-maskable and edge-triggered: a rising edge is captured and stays pending until it is acknowledged, even when the mask is 7. Software can raise a request at any level through a 7-bit force register. Each force request takes the lowest place in its level, and acknowledging it clears its bit. When several peripheral instances share one request line, their requests are OR-ed together outside the block.

Top module: `lvl_intc`

## Requirements
- R1: After reset, `irq_pend_o` is 0, `irq_lvl_o` is 0, `irq_vec_o` is 0, `ack_vld_o` is 0 and `frc_o` is 0.
- R2: A request line at level 1 to 6 is recognised only while it is high and its level is strictly greater than `mask_i`. The outputs reflect the inputs one clock edge after they change.
- R3: The highest level with an eligible request wins. Within a level, slot s (request index `(7-L)*SLOTS+s`) has priority 7-s, so a lower slot index wins. The force request of a level has priority 0 and loses to every peripheral line of that level.
- R4: The vector of a peripheral line is `SRC_BASE + VEC_BASE + index`, which is 65 + index with the default parameters. The vector of the force request at level L is `SRC_BASE + VEC_BASE + 7*SLOTS + (7-L)`, which is 114 for level 7 and 120 for level 1 with the default parameters.
- R5: A rising edge on a level-7 line is latched and stays pending after the line falls. It wins even when `mask_i` is 7.
- R6: One cycle after `iack_i` is high while a request is pending, `ack_vld_o` is 1 and `ack_vec_o` holds the vector that was presented. A level-7 latch acknowledged this way is cleared and re-arms only on a new rising edge of its line.
- R7: A write on `frc_wr_i` loads `frc_wdata_i` into the force register, shown on `frc_o` one clock later. Bit k of the register forces level 7-k. Acknowledging a force request clears its bit. Force bits never set except through a write.
- R8: When no request is eligible, `irq_pend_o` is 0, `irq_lvl_o` is 0 and `irq_vec_o` is 0.
- R9: When `iack_i` is high and nothing is pending, the acknowledge returns `SPUR_VEC` (24 by default) and clears no latch or force bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 7*SLOTS | Request lines; index (7-L)*SLOTS+s is level L, slot s |
| mask_i | input | 3 | Processor interrupt mask level |
| frc_wr_i | input | 1 | Force register write strobe |
| frc_wdata_i | input | 7 | Force register write data; bit k forces level 7-k |
| frc_o | output | 7 | Current force register contents |
| iack_i | input | 1 | Acknowledge request from the core |
| irq_pend_o | output | 1 | An eligible request is pending |
| irq_lvl_o | output | 3 | Level of the winning request, 0 when none |
| irq_vec_o | output | VEC_W | Vector of the winning request, 0 when none |
| ack_vld_o | output | 1 | Acknowledge response valid |
| ack_vec_o | output | VEC_W | Vector returned by the acknowledge |

## Verification
A table of request patterns on levels 1 to 6 is applied under several mask values. Some patterns put requests on two or three levels, which shows that level outranks slot. Some put two slots on one level, which shows the order within a level. Mask values equal to and just below a request's level show whether the level-versus-mask comparison is strict. Directed sequences then raise, drop and re-hold level-7 lines at mask 7. These show the edge latch apart from a level-sensitive input and show that an acknowledge re-arms a line only on a new edge. Force writes, alone and next to a peripheral line on the same level, check the force vectors, the bit clearing on acknowledge and the lowest-place priority. An acknowledge with nothing pending confirms that the spurious vector leaves all state untouched.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
  localparam int unsigned NUM_LVL = 7;
  localparam int unsigned LVL_W   = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/lvl_intc_edge7.sv
// Rising-edge capture for the non-maskable level. pend_o is the next latch
// state, so a fresh edge and an acknowledge clear are seen by arbitration
// in the same cycle they take effect.
module lvl_intc_edge7 #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] latch_d;
  logic [W-1:0] rise;

  always_comb begin
    rise    = req_i & ~prev_q;
    latch_d = (latch_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= req_i;
      latch_q <= latch_d;
    end
  end

  assign pend_o = latch_d;
endmodule

// File: rtl/lvl_intc_force.sv
// Software force register: a write replaces the contents, otherwise an
// acknowledge clears individual bits.
module lvl_intc_force #(
  parameter int unsigned LV = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [LV-1:0] wdata_i,
  input  logic [LV-1:0] clr_i,
  output logic [LV-1:0] frc_d_o,
  output logic [LV-1:0] frc_q_o
);
  logic [LV-1:0] frc_q;
  logic [LV-1:0] frc_d;
  logic          frc_en;

  always_comb begin
    frc_en = wr_i | (|clr_i);
    frc_d  = wr_i ? wdata_i : (frc_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frc_q <= '0;
    end else if (frc_en) begin
      frc_q <= frc_d;
    end
  end

  assign frc_d_o = frc_d;
  assign frc_q_o = frc_q;
endmodule

// File: rtl/lvl_intc_slot_pick.sv
// Fixed-priority pick inside one level: slot 0 first, force slot last.
// slot_o == SLOTS marks the force request.
module lvl_intc_slot_pick #(
  parameter int unsigned SLOTS = 7,
  localparam int unsigned SW   = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0] req_i,
  input  logic             frc_i,
  output logic             hit_o,
  output logic [SW-1:0]    slot_o
);
  always_comb begin
    hit_o  = (|req_i) | frc_i;
    slot_o = SW'(SLOTS);
    for (int s = int'(SLOTS) - 1; s >= 0; s--) begin
      if (req_i[s]) slot_o = SW'(s);
    end
  end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int unsigned SLOTS    = 7,
  parameter int unsigned SRC_BASE = 1,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned SPUR_VEC = 24,
  localparam int unsigned N_REQ   = NUM_LVL * SLOTS,
  localparam int unsigned SW      = $clog2(SLOTS + 1),
  localparam int unsigned RW      = $clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] irq_i,
  input  logic [2:0]       mask_i,
  input  logic             frc_wr_i,
  input  logic [6:0]       frc_wdata_i,
  output logic [6:0]       frc_o,
  input  logic             iack_i,
  output logic             irq_pend_o,
  output logic [2:0]       irq_lvl_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             ack_vld_o,
  output logic [VEC_W-1:0] ack_vec_o
);
  // Row r holds level 7-r; row 0 is the non-maskable level.
  logic [SLOTS-1:0]   e7_pend;
  logic [SLOTS-1:0]   e7_clr;
  logic [NUM_LVL-1:0] frc_clr;
  logic [NUM_LVL-1:0] frc_nxt;
  logic [NUM_LVL-1:0] row_hit;
  logic [NUM_LVL-1:0] row_ok;
  logic [SW-1:0]      row_slot [NUM_LVL];

  logic               win_found;
  logic [RW-1:0]      win_row;
  logic [SW-1:0]      win_slot;
  int unsigned        win_src;
  lvl_t               lvl_d;
  logic [VEC_W-1:0]   vec_d;

  logic               pend_q;
  lvl_t               lvl_q;
  logic [VEC_W-1:0]   vec_q;
  logic [RW-1:0]      row_q;
  logic [SW-1:0]      slot_q;
  logic               ackv_q;
  logic [VEC_W-1:0]   ackvec_q;
  logic [VEC_W-1:0]   ackvec_d;
  logic               ack_hit;

  // Acknowledge clears what the presented winner came from.
  always_comb begin
    ack_hit = iack_i & pend_q;
    frc_clr = '0;
    e7_clr  = '0;
    if (ack_hit && slot_q == SW'(SLOTS)) begin
      for (int r = 0; r < int'(NUM_LVL); r++) begin
        if (row_q == RW'(r)) frc_clr[r] = 1'b1;
      end
    end
    for (int s = 0; s < int'(SLOTS); s++) begin
      e7_clr[s] = ack_hit && (row_q == '0) && (slot_q == SW'(s));
    end
  end

  lvl_intc_edge7 #(.W(SLOTS)) u_edge7 (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_i[SLOTS-1:0]),
    .clr_i  (e7_clr),
    .pend_o (e7_pend)
  );

  lvl_intc_force #(.LV(NUM_LVL)) u_force (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (frc_wr_i),
    .wdata_i (frc_wdata_i),
    .clr_i   (frc_clr),
    .frc_d_o (frc_nxt),
    .frc_q_o (frc_o)
  );

  for (genvar r = 0; r < int'(NUM_LVL); r++) begin : g_row
    localparam lvl_t ROW_LVL = lvl_t'(NUM_LVL - r);
    logic [SLOTS-1:0] row_req;
    if (r == 0) begin : g_nmi
      assign row_req   = e7_pend;
      assign row_ok[r] = row_hit[r];
    end else begin : g_mask
      assign row_req   = irq_i[r*SLOTS +: SLOTS];
      assign row_ok[r] = row_hit[r] & (ROW_LVL > mask_i);
    end
    lvl_intc_slot_pick #(.SLOTS(SLOTS)) u_pick (
      .req_i  (row_req),
      .frc_i  (frc_nxt[r]),
      .hit_o  (row_hit[r]),
      .slot_o (row_slot[r])
    );
  end

  // Highest level first: row 0 overrides all others.
  always_comb begin
    win_found = 1'b0;
    win_row   = '0;
    win_slot  = '0;
    for (int r = int'(NUM_LVL) - 1; r >= 0; r--) begin
      if (row_ok[r]) begin
        win_found = 1'b1;
        win_row   = RW'(r);
        win_slot  = row_slot[r];
      end
    end
  end

  always_comb begin
    if (win_slot == SW'(SLOTS)) begin
      win_src = SRC_BASE + NUM_LVL * SLOTS + int'(win_row);
    end else begin
      win_src = SRC_BASE + int'(win_row) * SLOTS + int'(win_slot);
    end
    vec_d    = win_found ? VEC_W'(win_src + VEC_BASE) : '0;
    lvl_d    = win_found ? lvl_t'(NUM_LVL - int'(win_row)) : '0;
    ackvec_d = pend_q ? vec_q : VEC_W'(SPUR_VEC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
      vec_q  <= '0;
      row_q  <= '0;
      slot_q <= '0;
    end else begin
      pend_q <= win_found;
      lvl_q  <= lvl_d;
      vec_q  <= vec_d;
      row_q  <= win_row;
      slot_q <= win_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackv_q   <= 1'b0;
      ackvec_q <= '0;
    end else begin
      ackv_q <= iack_i;
      if (iack_i) ackvec_q <= ackvec_d;
    end
  end

  assign irq_pend_o = pend_q;
  assign irq_lvl_o  = lvl_q;
  assign irq_vec_o  = vec_q;
  assign ack_vld_o  = ackv_q;
  assign ack_vec_o  = ackvec_q;
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned SPUR_VEC = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mask_i,
  input logic             iack_i,
  input logic             frc_wr_i,
  input logic [6:0]       frc_o,
  input logic             irq_pend_o,
  input logic [2:0]       irq_lvl_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic             ack_vld_o,
  input logic [VEC_W-1:0] ack_vec_o
);
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend_o |-> (irq_lvl_o == 3'd0 && irq_vec_o == '0));

  assert_pend_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend_o |-> irq_lvl_o != 3'd0);

  assert_mask_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o && irq_lvl_o != 3'd7) |-> irq_lvl_o > $past(mask_i));

  assert_ack_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iack_i |=> ack_vld_o);

  assert_ack_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_i |=> !ack_vld_o);

  assert_ack_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && irq_pend_o) |=> ack_vec_o == $past(irq_vec_o));

  assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && !irq_pend_o) |=> ack_vec_o == VEC_W'(SPUR_VEC));

  assert_force_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frc_wr_i |=> (frc_o & ~$past(frc_o)) == 7'd0);
endmodule

bind lvl_intc lvl_intc_chk #(.VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mask_i     (mask_i),
  .iack_i     (iack_i),
  .frc_wr_i   (frc_wr_i),
  .frc_o      (frc_o),
  .irq_pend_o (irq_pend_o),
  .irq_lvl_o  (irq_lvl_o),
  .irq_vec_o  (irq_vec_o),
  .ack_vld_o  (ack_vld_o),
  .ack_vec_o  (ack_vec_o)
);

// File: tb/lvl_intc_bench.sv
`timescale 1ns/1ps
module lvl_intc_bench;
  localparam int N = 49;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] irq_i;
  logic [2:0]   mask_i;
  logic         frc_wr_i;
  logic [6:0]   frc_wdata_i;
  logic [6:0]   frc_o;
  logic         iack_i;
  logic         irq_pend_o;
  logic [2:0]   irq_lvl_o;
  logic [7:0]   irq_vec_o;
  logic         ack_vld_o;
  logic [7:0]   ack_vec_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lvl_intc u_lvl_intc (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_i(mask_i),
    .frc_wr_i(frc_wr_i), .frc_wdata_i(frc_wdata_i), .frc_o(frc_o),
    .iack_i(iack_i), .irq_pend_o(irq_pend_o), .irq_lvl_o(irq_lvl_o),
    .irq_vec_o(irq_vec_o), .ack_vld_o(ack_vld_o), .ack_vec_o(ack_vec_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Request index of level l, slot s.
  function automatic logic [N-1:0] rq(input int l, input int s);
    return {{(N-1){1'b0}}, 1'b1} << ((7 - l) * 7 + s);
  endfunction

  typedef struct packed {
    logic [N-1:0] irq;
    logic [2:0]   mask;
    logic         pend;
    logic [2:0]   lvl;
    logic [7:0]   vec;
  } row_t;

  localparam row_t TBL [0:9] = '{
    '{irq: '0,                                   mask: 3'd0, pend: 1'b0, lvl: 3'd0, vec: 8'd0},
    '{irq: 49'd1 << 48,                          mask: 3'd0, pend: 1'b1, lvl: 3'd1, vec: 8'd113},
    '{irq: 49'd1 << 48,                          mask: 3'd1, pend: 1'b0, lvl: 3'd0, vec: 8'd0},
    '{irq: (49'd1 << 30) | (49'd1 << 14),        mask: 3'd0, pend: 1'b1, lvl: 3'd5, vec: 8'd79},
    '{irq: (49'd1 << 30) | (49'd1 << 14),        mask: 3'd5, pend: 1'b0, lvl: 3'd0, vec: 8'd0},
    '{irq: (49'd1 << 30) | (49'd1 << 14),        mask: 3'd4, pend: 1'b1, lvl: 3'd5, vec: 8'd79},
    '{irq: (49'd1 << 11) | (49'd1 << 8),         mask: 3'd0, pend: 1'b1, lvl: 3'd6, vec: 8'd73},
    '{irq: (49'd1 << 11) | (49'd1 << 8),         mask: 3'd6, pend: 1'b0, lvl: 3'd0, vec: 8'd0},
    '{irq: (49'd1 << 35) | (49'd1 << 40) | (49'd1 << 27), mask: 3'd3, pend: 1'b1, lvl: 3'd4, vec: 8'd92},
    '{irq: (49'd1 << 35) | (49'd1 << 40) | (49'd1 << 27), mask: 3'd4, pend: 1'b0, lvl: 3'd0, vec: 8'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int pend, input int lvl, input int vec);
    chk(req, "pend", int'(irq_pend_o), pend);
    chk(req, "lvl",  int'(irq_lvl_o),  lvl);
    chk(req, "vec",  int'(irq_vec_o),  vec);
  endtask

  // Apply inputs at a falling edge, let one rising edge pass, sample at the next fall.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack();
    iack_i = 1'b1;
    step();
    iack_i = 1'b0;
  endtask

  task automatic wr_force(input logic [6:0] v);
    frc_wr_i    = 1'b1;
    frc_wdata_i = v;
    step();
    frc_wr_i    = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_i = '0; mask_i = 3'd0;
    frc_wr_i = 1'b0; frc_wdata_i = '0; iack_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_out("R1", 0, 0, 0);
    chk("R1", "ack_vld", int'(ack_vld_o), 0);
    chk("R1", "frc", int'(frc_o), 0);
    rst_n = 1'b1;
    step();
    chk_out("R1", 0, 0, 0);

    // Table walk over levels 1..6 (R2, R3, R4, R8)
    foreach (TBL[i]) begin
      irq_i  = TBL[i].irq;
      mask_i = TBL[i].mask;
      step();
      chk_out($sformatf("R2/R3/R4/R8 row%0d", i), int'(TBL[i].pend), int'(TBL[i].lvl), int'(TBL[i].vec));
    end
    irq_i = '0; mask_i = 3'd0;
    step();
    chk_out("R8", 0, 0, 0);

    // R5: level-7 edge latched, non-maskable, survives line drop
    mask_i = 3'd7;
    irq_i  = rq(7, 3);
    step();
    chk_out("R5", 1, 7, 68);
    irq_i = '0;
    step(); step();
    chk_out("R5", 1, 7, 68);
    // R3: higher slot at level 7 outranks the latched one
    irq_i = rq(7, 0);
    step();
    chk_out("R3", 1, 7, 65);
    irq_i = '0;
    // R6: acknowledge returns vector and clears that latch only
    ack();
    chk("R6", "ack_vld", int'(ack_vld_o), 1);
    chk("R6", "ack_vec", int'(ack_vec_o), 65);
    chk_out("R6", 1, 7, 68);
    ack();
    chk("R6", "ack_vec", int'(ack_vec_o), 68);
    chk_out("R6", 0, 0, 0);
    step();
    chk("R6", "ack_vld idle", int'(ack_vld_o), 0);

    // R6: held line does not retrigger after acknowledge
    irq_i = rq(7, 2);
    step();
    chk_out("R6", 1, 7, 67);
    ack();
    chk("R6", "ack_vec", int'(ack_vec_o), 67);
    step();
    chk_out("R6 held", 0, 0, 0);
    irq_i = '0;
    step();
    irq_i = rq(7, 2);
    step();
    chk_out("R6 rearm", 1, 7, 67);
    irq_i = '0;
    ack();
    chk_out("R6", 0, 0, 0);

    // R7: force register, bit 0 -> level 7, bit 6 -> level 1
    mask_i = 3'd0;
    wr_force(7'b1000001);
    chk("R7", "frc", int'(frc_o), 7'h41);
    chk_out("R7/R4", 1, 7, 114);
    ack();
    chk("R7", "ack_vec", int'(ack_vec_o), 114);
    chk("R7", "frc clear", int'(frc_o), 7'h40);
    chk_out("R7/R4", 1, 1, 120);
    mask_i = 3'd1;
    step();
    chk_out("R2", 0, 0, 0);
    // R9: spurious acknowledge clears nothing
    ack();
    chk("R9", "ack_vld", int'(ack_vld_o), 1);
    chk("R9", "ack_vec", int'(ack_vec_o), 24);
    chk("R9", "frc kept", int'(frc_o), 7'h40);
    mask_i = 3'd0;
    step();
    chk_out("R9", 1, 1, 120);
    ack();
    chk("R7", "ack_vec", int'(ack_vec_o), 120);
    chk("R7", "frc", int'(frc_o), 0);
    chk_out("R7", 0, 0, 0);

    // R3: force is lowest within its level (level 4, bit 3)
    wr_force(7'b0001000);
    irq_i = rq(4, 6);
    step();
    chk_out("R3", 1, 4, 92);
    irq_i = '0;
    step();
    chk_out("R3/R4", 1, 4, 117);
    wr_force(7'b0000000);
    chk_out("R7", 0, 0, 0);
    chk("R7", "frc", int'(frc_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule